// File: doc/BRIEF.md
# Transfer Address Generator With Cycle Splitting

This block holds the destination address of a data-transfer engine and turns each transfer request into one or more bus cycles. The engine loads the address through a dedicated load port; software has no direct path to it. A start strobe launches one logical transfer of byte, word or longword size. The block then issues a bus-cycle request that carries an address and an access size, and it holds that request until the bus acknowledges it.

The address can be used in two ways. In full mode all 32 stored bits form the bus address. In short mode only the low 24 bits count, and the top byte is filled with copies of bit 23. If the transfer size does not fit the address alignment, the block splits the transfer into narrower cycles, in ascending address order. When the last cycle has been acknowledged, the block pulses done and presents the address that follows the transfer, for use in increment-style sequencing.

The size code is 00 for a byte, 01 for a word and 10 for a longword. The code 11 is reserved and is handled as a byte. The mode and the size are sampled with the start strobe.

Top module: `xfer_addr_gen`

## Requirements
- R1: In full mode (short_mode_i=0) every bus-cycle address uses all 32 bits of the loaded address, plus the piece offset, modulo 2^32.
- R2: In short mode (short_mode_i=1) bits 31..24 of every emitted address (bus cycle and next address) equal bit 23 of the same address. Stored bits 31..24 have no effect.
- R3: A byte at any address, a word at an even address and a longword at an address with bits 1..0 = 00 each complete in one bus cycle of their own size (00 byte, 01 word, 10 longword). Size 11 behaves as a byte.
- R4: A word at an odd address A is issued as two byte cycles, to A and then to A+1.
- R5: A longword at an address with bits 1..0 = 10 is issued as two word cycles, to A and then to A+2.
- R6: A longword at an odd address A is issued as a byte to A, a word to A+1, then a byte to A+3.
- R7: A bus request stays asserted, with address and size unchanged, until ack_i is sampled high. The next piece is requested only after that.
- R8: done_o is high for exactly one clock, in the cycle after the clock edge that samples ack_i for the last piece. busy_o falls in the cycle after that.
- R9: next_addr_o takes the value A + (1, 2 or 4 bytes for the size) in the cycle when done_o rises, re-extended from bit 23 in short mode. It holds that value until the next transfer completes.
- R10: load_i and start_i are ignored while busy_o is high. A later transfer still uses the earlier address.
- R11: After reset, req_o, done_o and busy_o are low, and next_addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe for the destination address |
| load_addr_i | input | 32 | Address value to load |
| short_mode_i | input | 1 | 1 selects 24-bit short mode, sampled with start |
| size_i | input | 2 | Transfer size: 00 byte, 01 word, 10 longword |
| start_i | input | 1 | Starts one logical transfer when idle |
| ack_i | input | 1 | Acknowledge of the current bus cycle |
| busy_o | output | 1 | A transfer is in progress |
| req_o | output | 1 | Bus-cycle request |
| req_addr_o | output | 32 | Bus-cycle address |
| req_size_o | output | 2 | Bus-cycle size code |
| done_o | output | 1 | One-clock completion pulse |
| next_addr_o | output | 32 | Address following the completed transfer |

## Verification
The bench builds the block with its default parameters: a 32-bit address register and a 24-bit short window. With these values the short-mode tests can put an address just below the 24-bit boundary and watch the split pieces carry past bit 23. Each piece must then come out re-extended from bit 23. A full-mode longword at the top of the address space checks that the pieces wrap to zero. Acknowledges held back for several cycles check that the request stays stable while it waits.

// File: rtl/xag_pkg.sv
package xag_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSV  = 2'b11
  } xsize_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_DONE  = 2'b10
  } xstate_e;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_WORD: size_bytes = 3'd2;
      SZ_LONG: size_bytes = 3'd4;
      default: size_bytes = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/xag_addr_ext.sv
module xag_addr_ext #(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 24
) (
  input  logic [ADDR_W-1:0] raw_i,
  input  logic              short_i,
  output logic [ADDR_W-1:0] ext_o
);
  localparam int HI_W = ADDR_W - SHORT_W;

  generate
    if (HI_W > 0) begin : g_ext
      always_comb begin
        if (short_i) ext_o = {{HI_W{raw_i[SHORT_W-1]}}, raw_i[SHORT_W-1:0]};
        else         ext_o = raw_i;
      end
    end else begin : g_pass
      always_comb ext_o = raw_i;
    end
  endgenerate
endmodule

// File: rtl/xag_split_plan.sv
module xag_split_plan
  import xag_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic [1:0] addr_lo_i,
  input  logic [1:0] idx_i,
  output logic [1:0] piece_cnt_o,
  output logic [1:0] piece_sz_o,
  output logic [2:0] piece_bytes_o
);
  always_comb begin
    piece_cnt_o = 2'd1;
    piece_sz_o  = SZ_BYTE;
    case (size_i)
      SZ_WORD: begin
        if (addr_lo_i[0]) begin
          piece_cnt_o = 2'd2;
          piece_sz_o  = SZ_BYTE;
        end else begin
          piece_sz_o  = SZ_WORD;
        end
      end
      SZ_LONG: begin
        if (addr_lo_i[0]) begin
          piece_cnt_o = 2'd3;
          piece_sz_o  = (idx_i == 2'd1) ? SZ_WORD : SZ_BYTE;
        end else if (addr_lo_i[1]) begin
          piece_cnt_o = 2'd2;
          piece_sz_o  = SZ_WORD;
        end else begin
          piece_sz_o  = SZ_LONG;
        end
      end
      default: ;
    endcase
    piece_bytes_o = size_bytes(piece_sz_o);
  end
endmodule

// File: rtl/xag_seq.sv
module xag_seq
  import xag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       short_i,
  input  logic [1:0] size_i,
  input  logic       ack_i,
  input  logic [1:0] piece_cnt_i,
  input  logic [2:0] piece_bytes_i,
  output logic       busy_o,
  output logic       req_o,
  output logic       done_o,
  output logic       fin_o,
  output logic       short_q_o,
  output logic [1:0] size_q_o,
  output logic [1:0] idx_o,
  output logic [2:0] off_o
);
  xstate_e    st_q, st_d;
  logic [1:0] idx_q, idx_d;
  logic [2:0] off_q, off_d;
  logic [1:0] size_q, size_d;
  logic       short_q, short_d;
  logic       last_piece;

  assign last_piece = (idx_q == piece_cnt_i - 2'd1);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    off_d   = off_q;
    size_d  = size_q;
    short_d = short_q;
    fin_o   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_ISSUE;
          idx_d   = 2'd0;
          off_d   = 3'd0;
          size_d  = size_i;
          short_d = short_i;
        end
      end
      ST_ISSUE: begin
        if (ack_i) begin
          if (last_piece) begin
            st_d  = ST_DONE;
            fin_o = 1'b1;
          end else begin
            idx_d = idx_q + 2'd1;
            off_d = off_q + piece_bytes_i;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      off_q   <= '0;
      size_q  <= SZ_BYTE;
      short_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      off_q   <= off_d;
      size_q  <= size_d;
      short_q <= short_d;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign req_o     = (st_q == ST_ISSUE);
  assign done_o    = (st_q == ST_DONE);
  assign short_q_o = short_q;
  assign size_q_o  = size_q;
  assign idx_o     = idx_q;
  assign off_o     = off_q;

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(ack_i) && $past(req_o));
  a_r6_piece_bound: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> idx_q < piece_cnt_i);
endmodule

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
  import xag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SHORT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              short_mode_i,
  input  logic [1:0]        size_i,
  input  logic              start_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [1:0]        req_size_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] next_addr_o
);
  localparam int PAD_W = ADDR_W - 3;

  logic              rst_s1, rst_sync_n;
  logic [ADDR_W-1:0] dest_q, dest_d;
  logic [ADDR_W-1:0] nxt_q, nxt_d;
  logic [ADDR_W-1:0] piece_raw, nxt_raw, nxt_ext;
  logic              fin, short_q;
  logic [1:0]        size_q, idx, piece_cnt, piece_sz;
  logic [2:0]        off, piece_bytes;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  xag_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start_i),
    .short_i      (short_mode_i),
    .size_i       (size_i),
    .ack_i        (ack_i),
    .piece_cnt_i  (piece_cnt),
    .piece_bytes_i(piece_bytes),
    .busy_o       (busy_o),
    .req_o        (req_o),
    .done_o       (done_o),
    .fin_o        (fin),
    .short_q_o    (short_q),
    .size_q_o     (size_q),
    .idx_o        (idx),
    .off_o        (off)
  );

  xag_split_plan u_plan (
    .size_i       (size_q),
    .addr_lo_i    (dest_q[1:0]),
    .idx_i        (idx),
    .piece_cnt_o  (piece_cnt),
    .piece_sz_o   (piece_sz),
    .piece_bytes_o(piece_bytes)
  );

  assign piece_raw = dest_q + {{PAD_W{1'b0}}, off};
  assign nxt_raw   = dest_q + {{PAD_W{1'b0}}, size_bytes(size_q)};

  xag_addr_ext #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_ext_req (
    .raw_i  (piece_raw),
    .short_i(short_q),
    .ext_o  (req_addr_o)
  );

  xag_addr_ext #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W)) u_ext_nxt (
    .raw_i  (nxt_raw),
    .short_i(short_q),
    .ext_o  (nxt_ext)
  );

  assign req_size_o = piece_sz;

  always_comb begin
    dest_d = dest_q;
    if (load_i && !busy_o) dest_d = load_addr_i;
    nxt_d = nxt_q;
    if (fin) nxt_d = nxt_ext;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dest_q <= '0;
      nxt_q  <= '0;
    end else begin
      dest_q <= dest_d;
      nxt_q  <= nxt_d;
    end
  end

  assign next_addr_o = nxt_q;

  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_o && !ack_i |=> req_o && $stable(req_addr_o) && $stable(req_size_o));
  a_r10_load_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o && load_i |=> $stable(dest_q));
  a_r2_short_ext: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_o && short_q |-> req_addr_o[ADDR_W-1:SHORT_W] == {(ADDR_W-SHORT_W){req_addr_o[SHORT_W-1]}});
  a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_o |-> req_size_o != SZ_RSV);
endmodule

// File: tb/test_xfer_addr_gen.sv
module test_xfer_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] load_addr_i = '0;
  logic        short_mode_i = 1'b0;
  logic [1:0]  size_i = 2'b00;
  logic        start_i = 1'b0;
  logic        ack_i = 1'b0;
  logic        busy_o, req_o, done_o;
  logic [31:0] req_addr_o, next_addr_o;
  logic [1:0]  req_size_o;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  xfer_addr_gen i_xfer_addr_gen (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
    .short_mode_i(short_mode_i), .size_i(size_i), .start_i(start_i),
    .ack_i(ack_i), .busy_o(busy_o), .req_o(req_o), .req_addr_o(req_addr_o),
    .req_size_o(req_size_o), .done_o(done_o), .next_addr_o(next_addr_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ext(input logic [31:0] v, input logic s);
    return s ? {{8{v[23]}}, v[23:0]} : v;
  endfunction

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic load(input logic [31:0] a);
    load_addr_i = a; load_i = 1'b1; tick(); load_i = 1'b0;
  endtask

  // runs one transfer and compares every piece against the expected split
  task automatic xfer(input string req, input logic [31:0] a, input logic s,
                      input logic [1:0] sz, input int stall);
    int n;
    logic [2:0] offs [3];
    logic [1:0] szs [3];
    logic [2:0] tot;
    load(a);
    tot = (sz == 2'b01) ? 3'd2 : (sz == 2'b10) ? 3'd4 : 3'd1;
    if (sz == 2'b01 && a[0]) begin
      n = 2; offs[0] = 0; szs[0] = 0; offs[1] = 1; szs[1] = 0;
    end else if (sz == 2'b10 && a[0]) begin
      n = 3; offs[0] = 0; szs[0] = 0; offs[1] = 1; szs[1] = 1; offs[2] = 3; szs[2] = 0;
    end else if (sz == 2'b10 && a[1]) begin
      n = 2; offs[0] = 0; szs[0] = 1; offs[1] = 2; szs[1] = 1;
    end else begin
      n = 1; offs[0] = 0; szs[0] = (sz == 2'b11) ? 2'b00 : sz;
    end
    short_mode_i = s; size_i = sz; start_i = 1'b1; tick(); start_i = 1'b0;
    short_mode_i = ~s; size_i = 2'b11;
    for (int i = 0; i < n; i++) begin
      for (int w = 0; w < stall; w++) begin
        check({req, "/R7 hold"}, {31'd0, req_o}, 32'd1);
        check({req, "/R7 addr"}, req_addr_o, ext(a + 32'(offs[i]), s));
        tick();
      end
      check({req, "/req"}, {31'd0, req_o}, 32'd1);
      check({req, "/addr"}, req_addr_o, ext(a + 32'(offs[i]), s));
      check({req, "/size"}, {30'd0, req_size_o}, {30'd0, szs[i]});
      ack_i = 1'b1; tick(); ack_i = 1'b0;
    end
    check({req, "/R8 done"}, {31'd0, done_o}, 32'd1);
    check({req, "/R9 next"}, next_addr_o, ext(a + 32'(tot), s));
    tick();
    check({req, "/R8 pulse"}, {30'd0, done_o, busy_o}, 32'd0);
    check({req, "/R9 held"}, next_addr_o, ext(a + 32'(tot), s));
  endtask

  task automatic t_reset;
    check("R11 outs", {29'd0, req_o, done_o, busy_o}, 32'd0);
    check("R11 next", next_addr_o, 32'd0);
  endtask

  task automatic t_busy_ignore;
    load(32'h0000_1000);
    size_i = 2'b01; short_mode_i = 1'b0; start_i = 1'b1; tick(); start_i = 1'b0;
    load_addr_i = 32'hDEAD_BEE1; load_i = 1'b1; start_i = 1'b1; tick();
    load_i = 1'b0; start_i = 1'b0;
    check("R10 addr", req_addr_o, 32'h0000_1000);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    tick();
    check("R10 idle", {31'd0, busy_o}, 32'd0);
    size_i = 2'b00; start_i = 1'b1; tick(); start_i = 1'b0;
    check("R10 kept", req_addr_o, 32'h0000_1000);
    ack_i = 1'b1; tick(); ack_i = 1'b0; tick();
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rst_n = 1'b1;
        repeat (3) tick();
        t_reset();
        xfer("R1 R3 byte", 32'h1000_0003, 1'b0, 2'b00, 0);
        xfer("R3 rsv", 32'h1000_0005, 1'b0, 2'b11, 0);
        xfer("R3 word", 32'h2000_0002, 1'b0, 2'b01, 0);
        xfer("R3 long", 32'h3000_0004, 1'b0, 2'b10, 0);
        xfer("R4 word odd", 32'h8000_0001, 1'b0, 2'b01, 0);
        xfer("R5 long 4n+2", 32'h1234_5672, 1'b0, 2'b10, 0);
        xfer("R6 long odd", 32'h4000_0011, 1'b0, 2'b10, 0);
        xfer("R1 R6 wrap", 32'hFFFF_FFFF, 1'b0, 2'b10, 0);
        xfer("R2 short odd", 32'h00FF_FFFD, 1'b1, 2'b10, 0);
        xfer("R2 short word", 32'h5580_0000, 1'b1, 2'b01, 0);
        xfer("R2 short pos", 32'hAB7F_FFFE, 1'b1, 2'b10, 0);
        xfer("R7 stall", 32'h0000_0101, 1'b0, 2'b10, 4);
        t_busy_ignore();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule